// File: doc/BRIEF.md
# Two-Output Programmable Clock-Enable Divider

This block derives two divided clock enables from two incoming source ticks, all in the single domain of the system clock. Each source is presented as a one-cycle tick on `clk`: `lfTick` marks an edge of the slow crystal source and `dcoTick` marks an edge of the fast oscillator source. The auxiliary enable is always a divided copy of the slow ticks. The subsystem enable is a divided copy of whichever source is selected at run time. A third output passes oscillator ticks on as the processor clock enable, but only while the run input is high.

Software programs the block through two byte registers on a minimal bus: an address, a write strobe with write data, and read data that follows the address combinationally. The auxiliary register at 0x57 holds the auxiliary divide code. The subsystem register at 0x58 holds the source select and the subsystem divide code. A divide code `c` gives one enable pulse per 2^c source ticks. Each divider is a 3-bit counter that advances on its source tick. It is cleared whenever its register is written, so a new ratio starts from a known phase.

Top module: `pclk_divider`

## Requirements
- R1: After reset both registers read 0x00. The auxiliary enable then fires on every slow tick, and the subsystem enable fires on every oscillator tick.
- R2: Bits 5:4 of the register at 0x57 hold the auxiliary divide code c. Code 0 is /1, 1 is /2, 2 is /4 and 3 is /8. After the counter clears, `auxEn` fires on the 2^c-th, 2·2^c-th, ... slow tick, in the same cycle as that tick.
- R3: Bit 3 of the register at 0x58 selects the subsystem source: 1 is the slow ticks, 0 is the oscillator ticks. `subEn` is only ever high in a cycle where the active source ticks.
- R4: Bits 2:1 of the register at 0x58 hold the subsystem divide code. The encoding and pulse placement are the same as in R2, counted on ticks of the active source.
- R5: `auxEn` depends only on the slow ticks. It never fires without `lfTick`, whatever the subsystem source.
- R6: A write to one register address leaves the other register unchanged, whether the data is all ones or all zeros. A write to any other address changes neither register.
- R7: A register reads back what was written to its stored bits: bits 5:4 at 0x57 and bits 3:1 at 0x58. Every other bit reads 0, and every other address reads 0x00.
- R8: `cpuClkEn` equals `dcoTick` while `cpuRun` is 1 and is 0 while `cpuRun` is 0.
- R9: A write to a register clears that register's divider counter. A tick in the write cycle is judged with the old code and old count, and it is not counted afterwards.
- R10: A new source select takes effect on the first tick of the currently active source after the write. That tick is still judged on the old source, and the subsystem counter clears in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 16 | Byte address for read and write |
| busWrEn | input | 1 | Byte write strobe |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data for `busAddr` |
| lfTick | input | 1 | One-cycle tick per slow-source edge |
| dcoTick | input | 1 | One-cycle tick per oscillator edge |
| cpuRun | input | 1 | Processor clock run control |
| auxEn | output | 1 | Divided auxiliary clock enable |
| subEn | output | 1 | Divided subsystem clock enable |
| cpuClkEn | output | 1 | Gated processor clock enable |

## Verification
Two pairs of events can fall in the same cycle. The first pair is a register write and a tick of the source that register's divider counts. The second pair is a pending source change and a write to the subsystem register at the moment the old source ticks. The bench drives the two tick streams at periods that run independently of the bus traffic, and it rewrites each register partway through a dwell. This makes writes land both on ticks and between them. Every cycle is judged against an arithmetic model that applies R9 and R10 literally: the old code and old count decide the pulse, and then the counter is cleared.

// File: rtl/pclk_div_pkg.sv
package pclk_div_pkg;
  localparam int CODE_W = 2;                       // divide code width
  localparam int CNT_W  = (1 << CODE_W) - 1;       // counter reaches /8
  localparam int AUX_LSB = 4;                      // aux code field position
  localparam int SUB_LSB = 1;                      // sub code field position
  localparam int SEL_BIT = 3;                      // sub source select bit
  localparam logic [7:0] AUX_MASK = 8'(((1 << CODE_W) - 1) << AUX_LSB);
  localparam logic [7:0] SUB_MASK = 8'((((1 << CODE_W) - 1) << SUB_LSB) | (1 << SEL_BIT));

  typedef struct packed {
    logic auxClear;
    logic subClear;
  } div_strobe_t;
endpackage

// File: rtl/pclk_div_stage.sv
module pclk_div_stage
  import pclk_div_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              clear,
  input  logic [CODE_W-1:0] code,
  output logic              pulse
);
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] mask;

  // mask has code low bits set; pulse when those bits of the count are all one
  assign mask  = ~({CNT_W{1'b1}} << code);
  assign pulse = tick && ((count & mask) == mask);

  always_ff @(posedge clk) begin
    if (!rstN)       count <= '0;
    else if (clear)  count <= '0;
    else if (tick)   count <= count + 1'b1;
  end
endmodule

// File: rtl/pclk_div_ctrl.sv
module pclk_div_ctrl
  import pclk_div_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter logic [15:0] AUX_ADDR = 16'h0057,
  parameter logic [15:0] SUB_ADDR = 16'h0058
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [7:0]        busWrData,
  output logic [7:0]        busRdData,
  output logic [CODE_W-1:0] auxCode,
  output logic [CODE_W-1:0] subCode,
  output logic              subSelReq,
  output div_strobe_t       strobes
);
  logic [7:0] auxReg;
  logic [7:0] subReg;
  logic       auxHit;
  logic       subHit;

  assign auxHit = busWrEn && (busAddr == ADDR_W'(AUX_ADDR));
  assign subHit = busWrEn && (busAddr == ADDR_W'(SUB_ADDR));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      auxReg <= '0;
      subReg <= '0;
    end else begin
      if (auxHit) auxReg <= busWrData & AUX_MASK;
      if (subHit) subReg <= busWrData & SUB_MASK;
    end
  end

  always_comb begin
    if (busAddr == ADDR_W'(AUX_ADDR))      busRdData = auxReg;
    else if (busAddr == ADDR_W'(SUB_ADDR)) busRdData = subReg;
    else                                   busRdData = '0;
  end

  assign auxCode   = auxReg[AUX_LSB +: CODE_W];
  assign subCode   = subReg[SUB_LSB +: CODE_W];
  assign subSelReq = subReg[SEL_BIT];

  assign strobes.auxClear = auxHit;
  assign strobes.subClear = subHit;
endmodule

// File: rtl/pclk_div_datapath.sv
module pclk_div_datapath
  import pclk_div_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              lfTick,
  input  logic              dcoTick,
  input  logic              cpuRun,
  input  logic [CODE_W-1:0] auxCode,
  input  logic [CODE_W-1:0] subCode,
  input  logic              subSelReq,
  input  div_strobe_t       strobes,
  output logic              auxEn,
  output logic              subEn,
  output logic              cpuClkEn
);
  logic selActive;   // 1: slow source, 0: oscillator
  logic subTick;
  logic switchNow;

  assign subTick   = selActive ? lfTick : dcoTick;
  assign switchNow = subTick && (subSelReq != selActive);

  always_ff @(posedge clk) begin
    if (!rstN)          selActive <= 1'b0;
    else if (switchNow) selActive <= subSelReq;
  end

  pclk_div_stage u_auxStage (
    .clk   (clk),
    .rstN  (rstN),
    .tick  (lfTick),
    .clear (strobes.auxClear),
    .code  (auxCode),
    .pulse (auxEn)
  );

  pclk_div_stage u_subStage (
    .clk   (clk),
    .rstN  (rstN),
    .tick  (subTick),
    .clear (strobes.subClear | switchNow),
    .code  (subCode),
    .pulse (subEn)
  );

  assign cpuClkEn = dcoTick & cpuRun;
endmodule

// File: rtl/pclk_divider.sv
module pclk_divider
  import pclk_div_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter logic [15:0] AUX_ADDR = 16'h0057,
  parameter logic [15:0] SUB_ADDR = 16'h0058
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [7:0]        busWrData,
  output logic [7:0]        busRdData,
  input  logic              lfTick,
  input  logic              dcoTick,
  input  logic              cpuRun,
  output logic              auxEn,
  output logic              subEn,
  output logic              cpuClkEn
);
  logic [CODE_W-1:0] auxCode;
  logic [CODE_W-1:0] subCode;
  logic              subSelReq;
  div_strobe_t       strobes;

  pclk_div_ctrl #(
    .ADDR_W   (ADDR_W),
    .AUX_ADDR (AUX_ADDR),
    .SUB_ADDR (SUB_ADDR)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busAddr   (busAddr),
    .busWrEn   (busWrEn),
    .busWrData (busWrData),
    .busRdData (busRdData),
    .auxCode   (auxCode),
    .subCode   (subCode),
    .subSelReq (subSelReq),
    .strobes   (strobes)
  );

  pclk_div_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .lfTick    (lfTick),
    .dcoTick   (dcoTick),
    .cpuRun    (cpuRun),
    .auxCode   (auxCode),
    .subCode   (subCode),
    .subSelReq (subSelReq),
    .strobes   (strobes),
    .auxEn     (auxEn),
    .subEn     (subEn),
    .cpuClkEn  (cpuClkEn)
  );
endmodule

// File: rtl/pclk_divider_chk.sv
module pclk_divider_chk #(
  parameter int          ADDR_W   = 16,
  parameter logic [15:0] AUX_ADDR = 16'h0057,
  parameter logic [15:0] SUB_ADDR = 16'h0058
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic              lfTick,
  input logic              dcoTick,
  input logic              cpuRun,
  input logic              auxEn,
  input logic              subEn,
  input logic              cpuClkEn,
  input logic [1:0]        auxCode,
  input logic [1:0]        subCode,
  input logic              subSelReq
);
  AST_AUX_FROM_SLOW: assert property (@(posedge clk) disable iff (!rstN)
    auxEn |-> lfTick); // R5

  AST_AUX_DIV_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (lfTick && auxCode == 2'd0) |-> auxEn); // R2

  AST_SUB_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    subEn |-> (lfTick || dcoTick)); // R3

  AST_SUB_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == ADDR_W'(AUX_ADDR)) |=> ($stable(subCode) && $stable(subSelReq))); // R6

  AST_AUX_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == ADDR_W'(SUB_ADDR)) |=> $stable(auxCode)); // R6

  AST_CPU_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !cpuRun |-> !cpuClkEn); // R8
endmodule

bind pclk_divider pclk_divider_chk #(
  .ADDR_W   (ADDR_W),
  .AUX_ADDR (AUX_ADDR),
  .SUB_ADDR (SUB_ADDR)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busAddr   (busAddr),
  .busWrEn   (busWrEn),
  .lfTick    (lfTick),
  .dcoTick   (dcoTick),
  .cpuRun    (cpuRun),
  .auxEn     (auxEn),
  .subEn     (subEn),
  .cpuClkEn  (cpuClkEn),
  .auxCode   (auxCode),
  .subCode   (subCode),
  .subSelReq (subSelReq)
);

// File: tb/test_pclk_divider.sv
module test_pclk_divider;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [7:0]  busWrData = '0;
  logic [7:0]  busRdData;
  logic        lfTick = 1'b0;
  logic        dcoTick = 1'b0;
  logic        cpuRun = 1'b0;
  logic        auxEn, subEn, cpuClkEn;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  int phase  = 0;
  int lfPer  = 1;
  int dcoPer = 2;
  string rdTag = "R7";

  // requirement model
  int   mAuxCnt = 0, mSubCnt = 0;
  int   mAuxDiv = 0, mSubDiv = 0;
  logic mSel = 1'b0, mAct = 1'b0;

  always #5 clk = ~clk;

  pclk_divider i_pclk_divider (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .lfTick(lfTick),
    .dcoTick(dcoTick), .cpuRun(cpuRun), .auxEn(auxEn), .subEn(subEn),
    .cpuClkEn(cpuClkEn)
  );

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual %0d cycles, expected fewer than 100000", cycles);
      report();
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (phase %0d)", tag, act, exp, phase);
    end
  endtask

  function automatic bit hits(int cnt, int div);
    int m = (1 << div) - 1;
    return (cnt & m) == m;
  endfunction

  // one cycle: drive, check outputs against the model, advance the model
  task automatic step(input logic [15:0] a, input logic w, input logic [7:0] d);
    logic subT, expAux, expSub, sw;
    int   expRd;
    @(negedge clk);
    busAddr = a; busWrEn = w; busWrData = d;
    lfTick  = (phase % lfPer) == 0;
    dcoTick = (phase % dcoPer) == 0;
    cpuRun  = phase[4];
    #1;
    subT   = mAct ? lfTick : dcoTick;
    expAux = lfTick && hits(mAuxCnt, mAuxDiv);
    expSub = subT && hits(mSubCnt, mSubDiv);
    if (a == 16'h0057)      expRd = mAuxDiv << 4;
    else if (a == 16'h0058) expRd = (int'(mSel) << 3) | (mSubDiv << 1);
    else                    expRd = 0;
    chk("R2 R5 R9 auxEn", int'(auxEn), int'(expAux));
    chk("R3 R4 R9 R10 subEn", int'(subEn), int'(expSub));
    chk("R8 cpuClkEn", int'(cpuClkEn), int'(dcoTick && cpuRun));
    chk(rdTag, int'(busRdData), expRd);
    // model update
    sw = subT && (mSel != mAct);
    if (w && a == 16'h0057) begin mAuxCnt = 0; mAuxDiv = int'(d[5:4]); end
    else if (lfTick) mAuxCnt = (mAuxCnt + 1) & 7;
    if (w && a == 16'h0058) begin
      mSubCnt = 0; mSubDiv = int'(d[2:1]);
    end else if (sw) mSubCnt = 0;
    else if (subT) mSubCnt = (mSubCnt + 1) & 7;
    if (sw) mAct = mSel;
    if (w && a == 16'h0058) mSel = d[3];
    phase++;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state seen at the ports
    @(negedge clk);
    busAddr = 16'h0057; #1; chk("R1 aux reg reset", int'(busRdData), 0);
    busAddr = 16'h0058; #1; chk("R1 sub reg reset", int'(busRdData), 0);
    rdTag = "R1";
    for (int i = 0; i < 12; i++) step(16'h0057 + 16'(i % 2), 1'b0, 8'h00);
    rdTag = "R7";

    // sweep every code/select combination at several tick ratios
    for (int cfg = 0; cfg < 32; cfg++) begin
      logic [1:0] ac, sc;
      logic       sl;
      ac = 2'(cfg); sc = 2'(cfg >> 2); sl = cfg[4];
      lfPer  = 1 + (cfg % 3);
      dcoPer = 1 + (cfg % 2);
      step(16'h0057, 1'b1, {2'b11, ac, 4'hF});
      step(16'h0058, 1'b1, {4'hF, sl, sc, 1'b1});
      for (int k = 0; k < 40; k++) begin
        if (k == 17)      step(16'h0057, 1'b1, {2'b00, ac, 4'h0});   // R9 rewrite mid-run
        else if (k == 23) step(16'h0058, 1'b1, {4'h0, sl, sc, 1'b0}); // R9 R10
        else              step(16'h0056 + 16'(k % 4), 1'b0, 8'h00);
      end
    end

    // R6: register isolation with all-ones and all-zeros data
    rdTag = "R6";
    lfPer = 2; dcoPer = 1;
    step(16'h0057, 1'b1, 8'h00);
    step(16'h0058, 1'b1, 8'h00);
    step(16'h0057, 1'b1, 8'hFF);
    step(16'h0058, 1'b0, 8'h00);
    step(16'h0057, 1'b0, 8'h00);
    step(16'h0058, 1'b1, 8'hFF);
    step(16'h0057, 1'b0, 8'h00);
    step(16'h0058, 1'b0, 8'h00);
    step(16'h0057, 1'b1, 8'h00);
    step(16'h0058, 1'b0, 8'h00);
    step(16'h0059, 1'b1, 8'hFF);
    step(16'h0056, 1'b1, 8'hFF);
    step(16'h0057, 1'b0, 8'h00);
    step(16'h0058, 1'b0, 8'h00);
    rdTag = "R7";
    for (int i = 0; i < 40; i++) step(16'h0058, 1'b0, 8'h00);
    report();
  end
endmodule